// File: doc/BRIEF.md
# Attribute Controller Register Port

This block is the register side of a display attribute controller. A byte-wide host bus reaches it at two addresses. The host writes to one shared address, and those writes alternate between selecting a register and loading it. An internal phase toggle tracks which of the two the next write will be. The block stores 21 attribute registers. Each register keeps only the bits that are defined for it, and every undefined bit reads back as zero.

The host can get the phase back into a known state without knowing its current value. A one-cycle pulse on `stat_rd_i` forces the toggle to the selection phase. This pulse comes from the input-status read elsewhere in the display controller. Read data is combinational and appears in the same cycle as the read strobe. All state changes take effect on the rising clock edge.

Top module: `attr_ctl_port`

## Requirements
- R1: After reset the toggle is in the selection phase, the stored index is 0 and all 21 registers read back as 0.
- R2: Address 0 is the shared write address. Each write there flips the toggle. In the selection phase (toggle 0) the byte is taken as the index. In the load phase (toggle 1) the byte goes to the register numbered by bits 4:0 of the index.
- R3: The stored index keeps only bits 5:0 of the written byte. A read of address 0 returns the index in the selection phase and returns 0 in the load phase. A load-phase write leaves the index unchanged.
- R4: Registers 0 to 15 keep bits 5:0 of a loaded byte and hold bits 7:6 at 0.
- R5: Register 16 stores the byte with bit 4 forced to 0. Register 17 stores the whole byte.
- R6: Register 18 forces bits 7:6 to 0. Registers 19 and 20 force bits 7:4 to 0.
- R7: A load-phase write whose index bits 4:0 exceed 20 changes no register, and the toggle still flips.
- R8: A read of address 1 returns the register numbered by index bits 4:0 when that number is below 21, and returns 0 otherwise.
- R9: A `stat_rd_i` pulse leaves the toggle at 0 after the edge. This takes priority over the flip from a write in the same cycle. That write is still handled according to the phase in effect before the edge.
- R10: `rdata_o` is 0 whenever `rd_i` is low or the address is 2 or 3. Writes to addresses 1, 2 and 3 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 2 | Port select: 0 index/load, 1 register read |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| stat_rd_i | input | 1 | Input-status read pulse; clears the toggle |
| rdata_o | output | 8 | Combinational read data |

## Verification
The sweep writes all 64 index values, with different top two bits, against five data patterns. It catches two kinds of error: a design that drops bit 5 of the index from readback, and one that uses bit 5 to select the register. Both would show a wrong index or a write landing on the wrong register. Per-register masks are checked on each register separately, so a mask applied to the wrong neighbour shows up as a readback that is too wide or too narrow. A final pass over all registers catches out-of-range loads that wrongly wrap onto low registers. Further directed cases cover these errors:
- a status pulse that arrives together with a write and loses to the flip, which would leave the toggle in the wrong phase;
- writes to the read-only address that flip the toggle;
- reads that leak data while the strobe is low.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned IDX_W    = 6;
  localparam int unsigned SEL_W    = 5;
  localparam int unsigned NUM_REGS = 21;
  localparam int unsigned ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] ADDR_IDX = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DRD = 2'd1;

  // Bits that survive a load into register n.
  function automatic logic [DW-1:0] keep_mask(input int unsigned n);
    logic [DW-1:0] m;
    if (n < 16)                 m = 8'h3F;
    else if (n == 16)           m = 8'hEF;
    else if (n == 17)           m = 8'hFF;
    else if (n == 18)           m = 8'h3F;
    else if (n == 19 || n == 20) m = 8'h0F;
    else                        m = 8'h00;
    return m;
  endfunction
endpackage

// File: rtl/attr_rst_sync.sv
module attr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/attr_phase.sv
module attr_phase
  import attr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             port_wr_i,
  input  logic             stat_clr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             toggle_o,
  output logic [IDX_W-1:0] index_o,
  output logic             load_o
);
  logic             toggle_q, toggle_d, toggle_en;
  logic [IDX_W-1:0] index_q, index_d;
  logic             index_en;

  always_comb begin
    toggle_en = port_wr_i | stat_clr_i;
    if (stat_clr_i) toggle_d = 1'b0;
    else            toggle_d = ~toggle_q;
    index_en = port_wr_i & ~toggle_q;
    index_d  = wdata_i[IDX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        toggle_q <= 1'b0;
    else if (toggle_en) toggle_q <= toggle_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       index_q <= '0;
    else if (index_en) index_q <= index_d;
  end

  assign toggle_o = toggle_q;
  assign index_o  = index_q;
  assign load_o   = port_wr_i & toggle_q;
endmodule

// File: rtl/attr_bank.sv
module attr_bank
  import attr_pkg::*;
#(
  parameter int unsigned N = NUM_REGS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [N-1:0][DW-1:0]  regs_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam logic [DW-1:0] MASK = keep_mask(g);
    logic          en;
    logic [DW-1:0] d, q;

    always_comb begin
      en = load_i && (sel_i == SEL_W'(g));
      d  = wdata_i & MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (en) q <= d;
    end

    assign regs_o[g] = q;
  end
endmodule

// File: rtl/attr_rdmux.sv
module attr_rdmux
  import attr_pkg::*;
#(
  parameter int unsigned N = NUM_REGS
) (
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 toggle_i,
  input  logic [IDX_W-1:0]     index_i,
  input  logic [N-1:0][DW-1:0] regs_i,
  output logic [DW-1:0]        rdata_o
);
  logic [DW-1:0] reg_sel;
  logic [SEL_W-1:0] sel;

  always_comb begin
    sel     = index_i[SEL_W-1:0];
    reg_sel = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (sel == SEL_W'(i)) reg_sel = regs_i[i];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_IDX: rdata_o = toggle_i ? '0 : DW'(index_i);
        ADDR_DRD: rdata_o = reg_sel;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/attr_ctl_port.sv
module attr_ctl_port
  import attr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              stat_rd_i,
  output logic [DW-1:0]     rdata_o
);
  logic                        rst_sync_n;
  logic                        port_wr;
  logic                        toggle_q;
  logic [IDX_W-1:0]            index_q;
  logic                        load;
  logic [NUM_REGS-1:0][DW-1:0] regs;

  assign port_wr = wr_i && (addr_i == ADDR_IDX);

  attr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  attr_phase u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .port_wr_i  (port_wr),
    .stat_clr_i (stat_rd_i),
    .wdata_i    (wdata_i),
    .toggle_o   (toggle_q),
    .index_o    (index_q),
    .load_o     (load)
  );

  attr_bank #(.N(NUM_REGS)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .load_i  (load),
    .sel_i   (index_q[SEL_W-1:0]),
    .wdata_i (wdata_i),
    .regs_o  (regs)
  );

  attr_rdmux #(.N(NUM_REGS)) u_rdmux (
    .rd_i     (rd_i),
    .addr_i   (addr_i),
    .toggle_i (toggle_q),
    .index_i  (index_q),
    .regs_i   (regs),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/attr_ctl_port_chk.sv
module attr_ctl_port_chk
  import attr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              stat_rd_i,
  input logic [DW-1:0]     rdata_o,
  input logic              toggle_q,
  input logic [IDX_W-1:0]  index_q
);
  logic port_wr, drd;
  assign port_wr = wr_i && addr_i == ADDR_IDX;
  assign drd     = rd_i && addr_i == ADDR_DRD;

  AST_TOGGLE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_n)
    port_wr && !stat_rd_i |=> toggle_q != $past(toggle_q)); // R2
  AST_STAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n)
    stat_rd_i |=> !toggle_q); // R9
  AST_IDX_RD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_i && addr_i == ADDR_IDX && toggle_q |-> rdata_o == '0); // R3
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    port_wr && toggle_q |=> $stable(index_q)); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rd_i |-> rdata_o == '0); // R10
  AST_LOW_MASK: assert property (@(posedge clk_i) disable iff (!rst_n)
    drd && index_q[4:0] < 5'd16 |-> rdata_o[7:6] == 2'b00); // R4
  AST_BIT4_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n)
    drd && index_q[4:0] == 5'd16 |-> rdata_o[4] == 1'b0); // R5
  AST_HIGH_SEL: assert property (@(posedge clk_i) disable iff (!rst_n)
    drd && index_q[4:0] > 5'd20 |-> rdata_o == '0); // R8
endmodule

bind attr_ctl_port attr_ctl_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .stat_rd_i (stat_rd_i),
  .rdata_o   (rdata_o),
  .toggle_q  (toggle_q),
  .index_q   (index_q)
);

// File: tb/attr_ctl_port_tb.sv
module attr_ctl_port_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       rd_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       stat_rd_i = 1'b0;
  logic [7:0] rdata_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_reg [21];
  logic [5:0] m_idx;
  bit         m_tog;

  attr_ctl_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .stat_rd_i(stat_rd_i), .rdata_o(rdata_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [7:0] mask_of(int s);
    if (s < 16) return 8'h3F;
    if (s == 16) return 8'hEF;
    if (s == 17) return 8'hFF;
    if (s == 18) return 8'h3F;
    if (s < 21) return 8'h0F;
    return 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  // model of one write at the shared address, with optional status pulse
  task automatic model_port_wr(logic [7:0] d, bit stat);
    if (!m_tog) m_idx = d[5:0];
    else if (int'(m_idx[4:0]) < 21) m_reg[m_idx[4:0]] = d & mask_of(int'(m_idx[4:0]));
    m_tog = stat ? 1'b0 : !m_tog;
  endtask

  task automatic do_wr(logic [1:0] a, logic [7:0] d, bit stat);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1; stat_rd_i = stat;
    @(posedge clk_i); #1;
    wr_i = 1'b0; stat_rd_i = 1'b0;
    if (a == 2'd0) model_port_wr(d, stat);
    else if (stat) m_tog = 1'b0;
  endtask

  task automatic do_stat();
    @(negedge clk_i);
    stat_rd_i = 1'b1;
    @(posedge clk_i); #1;
    stat_rd_i = 1'b0;
    m_tog = 1'b0;
  endtask

  task automatic do_rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 v = rdata_o;
    @(posedge clk_i); #1;
    rd_i = 1'b0;
  endtask

  function automatic logic [7:0] exp_drd();
    if (int'(m_idx[4:0]) < 21) return m_reg[m_idx[4:0]];
    return 8'h00;
  endfunction

  function automatic string tag_of(int s);
    if (s < 16) return "R4";
    if (s < 18) return "R5";
    if (s < 21) return "R6";
    return "R7";
  endfunction

  task automatic reset_all();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);
    for (int i = 0; i < 21; i++) m_reg[i] = 8'h00;
    m_idx = '0; m_tog = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] pats [5];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    pats[3] = 8'h5A; pats[4] = 8'h3C;

    reset_all();
    // R1: reset state
    do_rd(2'd0, v); check("R1 index", v, 8'h00);
    do_rd(2'd1, v); check("R1 reg0", v, 8'h00);

    // R2..R8 sweep over all indices and patterns
    for (int i = 0; i < 64; i++) begin
      for (int p = 0; p < 5; p++) begin
        logic [7:0] ib;
        ib = {pats[p][7:6], 6'(i)};
        do_wr(2'd0, ib, 1'b0);
        do_rd(2'd0, v); check("R3 load-phase index read", v, 8'h00);
        do_wr(2'd0, pats[p] ^ 8'(i), 1'b0);
        do_rd(2'd0, v); check("R2 R3 index readback", v, 8'(i));
        do_rd(2'd1, v); check({tag_of(i % 32), " R8 data read"}, v, exp_drd());
      end
    end

    // R7: final pass over all registers after out-of-range loads
    for (int s = 0; s < 21; s++) begin
      do_wr(2'd0, 8'(s), 1'b0);
      do_rd(2'd1, v); check({tag_of(s), " R7 final"}, v, m_reg[s]);
      do_stat();
      do_rd(2'd0, v); check("R9 status clears toggle", v, 8'(s));
    end

    // R9: status together with an index-phase write
    do_wr(2'd0, 8'hD7, 1'b1);
    do_rd(2'd0, v); check("R9 index write with status", v, 8'h17);
    // R9: status together with a load-phase write
    do_wr(2'd0, 8'h03, 1'b0);
    do_wr(2'd0, 8'h2A, 1'b1);
    do_rd(2'd0, v); check("R9 load with status phase", v, 8'h03);
    do_rd(2'd1, v); check("R9 load with status data", v, 8'h2A);

    // R10: other addresses and idle strobe
    do_wr(2'd1, 8'h11, 1'b0);
    do_wr(2'd3, 8'h22, 1'b0);
    do_wr(2'd2, 8'h33, 1'b0);
    do_rd(2'd0, v); check("R10 writes elsewhere ignored", v, 8'h03);
    do_rd(2'd1, v); check("R10 reg unchanged", v, m_reg[3]);
    do_rd(2'd2, v); check("R10 unmapped read 2", v, 8'h00);
    do_rd(2'd3, v); check("R10 unmapped read 3", v, 8'h00);
    @(negedge clk_i); addr_i = 2'd1; #1;
    check("R10 idle rdata", rdata_o, 8'h00);

    // R1: reset mid-run clears everything
    reset_all();
    for (int s = 0; s < 21; s++) begin
      do_wr(2'd0, 8'(s), 1'b0);
      do_rd(2'd1, v); check("R1 reg after reset", v, 8'h00);
      do_stat();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule